// File: doc/BRIEF.md
# Calendar-Sequenced Channel Status Tracker

This block takes in a stream of 2-bit flow-control status values, one per status slot, and files each value into a table that keeps one status per channel. Which channel a slot belongs to is not fixed: a calendar memory, loaded by a host, holds a channel number for each slot position. A sequencer walks through the calendar one entry per received status. It repeats the calendar a programmable number of times and then expects one framing slot before it starts again at entry 0.

The host writes calendar entries through an address/data port with an active-low write enable. With the enable released, the same address bus selects an entry to read back. A separate read port returns the status of sixteen neighbouring channels as one packed 32-bit word, one cycle after the group index is presented. The code value 11 is reserved for framing and never lands in the table. A build-time switch can remove the table. In that build only the most recent accepted status is kept, and it appears on the read word's low pair and on its own output.

Everything runs on one clock with an asynchronous active-low reset. After reset every channel reads satisfied, so a transmitter gated by this table sends nothing until real status arrives.

Top module: `cal_status_tracker`

## Requirements
- R1: On a rising clock edge with `cal_we_n` low, the calendar entry at `cal_addr` takes the value of `cal_wdata`.
- R2: On an edge with `cal_we_n` high, `cal_rdata` takes the entry stored at `cal_addr` before that edge. On an edge with `cal_we_n` low, `cal_rdata` keeps its value. Reset clears it to 0.
- R3: Each edge with `stat_vld` high and `resync` low consumes one status slot. In a normal slot, the channel named by the calendar entry at the current position receives `stat_val`. Positions advance in ascending order starting at entry 0.
- R4: After the slot at position `cfg_last` (or at any position at or above it), the position returns to 0. Once the calendar has been walked `cfg_reps`+1 times, the next slot is a framing slot: its value is discarded, and the walk then restarts at entry 0 with the repetition count cleared.
- R5: A slot carrying 11 (framing) changes no channel and does not change `last_stat`, but it still advances the position as in R3 and R4. Codes: 00 starving, 01 hungry, 10 satisfied.
- R6: An edge with `resync` high returns the position to entry 0, clears the repetition count and any pending framing slot, and discards any status presented in that cycle.
- R7: After reset every channel holds 10 (satisfied), `last_stat` is 10 and the position is entry 0.
- R8: `rd_data` is a registered copy of group `rd_grp` as the table stood before the edge. Channel 16·g+k sits at bits [2k+1:2k], so the lowest channel of a group is in the least-significant pair.
- R9: `last_stat` holds the value most recently written into the table.
- R10: An edge with `stat_vld` and `resync` both low leaves the position, the table and `last_stat` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst_n | input | 1 | Asynchronous reset, active low |
| cal_we_n | input | 1 | Calendar write enable, active low |
| cal_addr | input | 9 | Calendar entry for write or readback |
| cal_wdata | input | 8 | Channel number to store |
| cal_rdata | output | 8 | Calendar entry read back |
| cfg_last | input | 9 | Position of the last valid calendar entry |
| cfg_reps | input | 8 | Extra walks of the calendar before a framing slot |
| stat_vld | input | 1 | One status slot received this cycle |
| stat_val | input | 2 | Received status value |
| resync | input | 1 | Restart the sequencer at entry 0 |
| rd_grp | input | 4 | Group index for the packed read |
| rd_data | output | 32 | Sixteen channels' status, lowest channel in bits [1:0] |
| last_stat | output | 2 | Most recently accepted status |

## Verification
The bench builds the block with its default parameters: a 512-entry calendar, 256 channels, 16 read groups and the full table. The whole calendar is loaded and read back. Short calendar lengths (0 to 15) and repetition counts (0 to 3) are then programmed, so that wraps, framing slots and a length lowered below the current position all occur thousands of times in a short run. The group index is random in every cycle, so every packing position is compared against the bench's own table model.

// File: rtl/cst_pkg.sv
package cst_pkg;

  typedef enum logic [1:0] {
    ST_STARVE = 2'b00,
    ST_HUNGRY = 2'b01,
    ST_SAT    = 2'b10,
    ST_FRAME  = 2'b11
  } fc_stat_e;

  // a value other than the framing pattern carries channel status
  function automatic logic carries_status(input logic [1:0] v);
    return v != ST_FRAME;
  endfunction

  // lowest bit of group grp when each group is grp_bits wide
  function automatic int grp_lsb(input int grp, input int grp_bits);
    return grp * grp_bits;
  endfunction

endpackage

// File: rtl/cst_cal_ram.sv
module cst_cal_ram #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [AW-1:0] seq_addr,
  output logic [DW-1:0] seq_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!we_n) mem[addr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata <= '0;
    else if (we_n) rdata <= mem[addr];
  end

  assign seq_data = mem[seq_addr];

  // R2
  hold_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |=> $stable(rdata));

  // R1
  write_then_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(we_n) && we_n && addr == $past(addr)) |=> rdata == $past(wdata, 2));

endmodule

// File: rtl/cst_slot_seq.sv
module cst_slot_seq
  import cst_pkg::*;
#(
  parameter int AW = 9,
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stat_vld,
  input  logic [1:0]    stat_val,
  input  logic          resync,
  input  logic [AW-1:0] cfg_last,
  input  logic [RW-1:0] cfg_reps,
  output logic [AW-1:0] slot_idx,
  output logic          in_gap,
  output logic          slot_take,
  output logic          slot_write,
  output logic          gap_slot,
  output logic          wrap_evt
);
  logic [RW-1:0] rep_cnt;
  logic          at_end;
  logic          reps_done;

  always_comb begin
    slot_take  = stat_vld && !resync && !in_gap;
    gap_slot   = stat_vld && !resync && in_gap;
    slot_write = slot_take && carries_status(stat_val);
    at_end     = slot_idx >= cfg_last;
    wrap_evt   = slot_take && at_end;
    reps_done  = rep_cnt >= cfg_reps;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_idx <= '0;
      rep_cnt  <= '0;
      in_gap   <= 1'b0;
    end else if (resync) begin
      slot_idx <= '0;
      rep_cnt  <= '0;
      in_gap   <= 1'b0;
    end else if (gap_slot) begin
      slot_idx <= '0;
      rep_cnt  <= '0;
      in_gap   <= 1'b0;
    end else if (wrap_evt) begin
      slot_idx <= '0;
      if (reps_done) begin
        in_gap  <= 1'b1;
        rep_cnt <= '0;
      end else begin
        rep_cnt <= rep_cnt + 1'b1;
      end
    end else if (slot_take) begin
      slot_idx <= slot_idx + 1'b1;
    end
  end

  // R6
  resync_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> (slot_idx == '0 && !in_gap));

  // R4
  wrap_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_vld && !resync && !in_gap && slot_idx >= cfg_last) |=> slot_idx == '0);

  // R4
  gap_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_vld && !resync && in_gap) |=> (!in_gap && slot_idx == '0));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_vld && !resync) |=> ($stable(slot_idx) && $stable(in_gap)));

  // R3
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_vld && !resync && !in_gap && slot_idx < cfg_last) |=> slot_idx == $past(slot_idx) + 1'b1);

endmodule

// File: rtl/cst_stat_table.sv
module cst_stat_table
  import cst_pkg::*;
#(
  parameter int CW        = 8,
  parameter int RD_W      = 32,
  parameter int GRP_W     = CW - $clog2(RD_W / 2),
  parameter bit USE_TABLE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CW-1:0]    wr_ch,
  input  logic [1:0]       wr_val,
  input  logic [GRP_W-1:0] rd_grp,
  output logic [RD_W-1:0]  rd_data,
  output logic [1:0]       last_stat
);
  localparam int NCH = 1 << CW;

  logic [2*NCH-1:0] flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     last_stat <= ST_SAT;
    else if (wr_en) last_stat <= wr_val;
  end

  if (USE_TABLE) begin : g_full
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [1:0] st;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          st <= ST_SAT;
        else if (wr_en && wr_ch == CW'(c))   st <= wr_val;
      end
      assign flat[2*c +: 2] = st;
    end
  end else begin : g_lite
    assign flat = {{(2*NCH-2){1'b0}}, last_stat};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= flat[grp_lsb(int'(rd_grp), RD_W) +: RD_W];
  end

  // R5
  no_frame_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_val != ST_FRAME);

  // R9
  last_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> last_stat == $past(wr_val));

  // R10
  last_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(last_stat));

endmodule

// File: rtl/cal_status_tracker.sv
module cal_status_tracker
  import cst_pkg::*;
#(
  parameter int CAL_AW    = 9,
  parameter int CH_W      = 8,
  parameter int REP_W     = 8,
  parameter int RD_W      = 32,
  parameter bit USE_TABLE = 1'b1
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cal_we_n,
  input  logic [CAL_AW-1:0]                   cal_addr,
  input  logic [CH_W-1:0]                     cal_wdata,
  output logic [CH_W-1:0]                     cal_rdata,
  input  logic [CAL_AW-1:0]                   cfg_last,
  input  logic [REP_W-1:0]                    cfg_reps,
  input  logic                                stat_vld,
  input  logic [1:0]                          stat_val,
  input  logic                                resync,
  input  logic [CH_W-$clog2(RD_W/2)-1:0]      rd_grp,
  output logic [RD_W-1:0]                     rd_data,
  output logic [1:0]                          last_stat
);
  localparam int GRP_W = CH_W - $clog2(RD_W / 2);

  logic [CAL_AW-1:0] slot_idx;
  logic [CH_W-1:0]   slot_ch;
  logic              in_gap;
  logic              slot_take;
  logic              slot_write;
  logic              gap_slot;
  logic              wrap_evt;

  cst_cal_ram #(.AW(CAL_AW), .DW(CH_W)) u_cal (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_n     (cal_we_n),
    .addr     (cal_addr),
    .wdata    (cal_wdata),
    .rdata    (cal_rdata),
    .seq_addr (slot_idx),
    .seq_data (slot_ch)
  );

  cst_slot_seq #(.AW(CAL_AW), .RW(REP_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .stat_vld   (stat_vld),
    .stat_val   (stat_val),
    .resync     (resync),
    .cfg_last   (cfg_last),
    .cfg_reps   (cfg_reps),
    .slot_idx   (slot_idx),
    .in_gap     (in_gap),
    .slot_take  (slot_take),
    .slot_write (slot_write),
    .gap_slot   (gap_slot),
    .wrap_evt   (wrap_evt)
  );

  cst_stat_table #(.CW(CH_W), .RD_W(RD_W), .GRP_W(GRP_W), .USE_TABLE(USE_TABLE)) u_tab (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (slot_write),
    .wr_ch     (slot_ch),
    .wr_val    (stat_val),
    .rd_grp    (rd_grp),
    .rd_data   (rd_data),
    .last_stat (last_stat)
  );

  // R5
  frame_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_take && stat_val == ST_FRAME) |=> $stable(last_stat));

  // R4
  gap_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gap_slot |-> !slot_write);

  // R6
  resync_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> $stable(last_stat));

  // R4
  wrap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wrap_evt, gap_slot}));

endmodule

// File: tb/test_cal_status_tracker.sv
module test_cal_status_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 9;
  localparam int CW = 8;
  localparam int RW = 8;
  localparam int NCH = 1 << CW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cal_we_n = 1'b1;
  logic [AW-1:0] cal_addr = '0;
  logic [CW-1:0] cal_wdata = '0;
  logic [CW-1:0] cal_rdata;
  logic [AW-1:0] cfg_last = '0;
  logic [RW-1:0] cfg_reps = '0;
  logic          stat_vld = 1'b0;
  logic [1:0]    stat_val = 2'b00;
  logic          resync = 1'b0;
  logic [3:0]    rd_grp = '0;
  logic [31:0]   rd_data;
  logic [1:0]    last_stat;

  always #(CLK_PERIOD/2) clk = ~clk;

  cal_status_tracker i_cal_status_tracker (
    .clk(clk), .rst_n(rst_n), .cal_we_n(cal_we_n), .cal_addr(cal_addr),
    .cal_wdata(cal_wdata), .cal_rdata(cal_rdata), .cfg_last(cfg_last),
    .cfg_reps(cfg_reps), .stat_vld(stat_vld), .stat_val(stat_val),
    .resync(resync), .rd_grp(rd_grp), .rd_data(rd_data), .last_stat(last_stat)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string tag = "R7";

  logic [CW-1:0] cal_m [DEPTH];
  logic [1:0]    tab_m [NCH];
  int            m_idx, m_rep;
  bit            m_gap;
  logic [1:0]    m_last;
  logic [CW-1:0] m_cal_rd;
  logic [31:0]   m_rd;

  function automatic logic [31:0] group_of(input int g);
    logic [31:0] w;
    for (int k = 0; k < 16; k++) w[2*k +: 2] = tab_m[g*16 + k];
    return w;
  endfunction

  task automatic chk(input string t, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", t, what, act, exp, $time);
    end
  endtask

  // model of one edge, computed from the inputs held since the last falling edge
  task automatic model_edge();
    m_rd = group_of(int'(rd_grp));
    if (cal_we_n) m_cal_rd = cal_m[cal_addr];
    if (resync) begin
      m_idx = 0; m_rep = 0; m_gap = 1'b0;
    end else if (stat_vld) begin
      if (m_gap) begin
        m_gap = 1'b0; m_idx = 0; m_rep = 0;
      end else begin
        if (stat_val != 2'b11) begin
          tab_m[cal_m[m_idx]] = stat_val;
          m_last = stat_val;
        end
        if (m_idx >= int'(cfg_last)) begin
          m_idx = 0;
          if (m_rep >= int'(cfg_reps)) begin m_gap = 1'b1; m_rep = 0; end
          else m_rep++;
        end else m_idx++;
      end
    end
    if (!cal_we_n) cal_m[cal_addr] = cal_wdata;
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(tag, "rd_data R8", rd_data, m_rd);
    chk(tag, "cal_rdata R2", {24'd0, cal_rdata}, {24'd0, m_cal_rd});
    chk(tag, "last_stat R9", {30'd0, last_stat}, {30'd0, m_last});
  endtask

  task automatic idle_inputs();
    cal_we_n = 1'b1; stat_vld = 1'b0; resync = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int c = 0; c < NCH; c++) tab_m[c] = 2'b10;
    for (int a = 0; a < DEPTH; a++) cal_m[a] = '0;
    m_idx = 0; m_rep = 0; m_gap = 1'b0; m_last = 2'b10; m_cal_rd = '0; m_rd = '0;
    repeat (3) @(negedge clk);
    // R7: reset state of outputs
    chk("R7", "cal_rdata in reset", {24'd0, cal_rdata}, 32'd0);
    chk("R7", "last_stat in reset", {30'd0, last_stat}, 32'd2);
    rst_n = 1'b1;

    // R7: every group reads all-satisfied
    tag = "R7";
    for (int g = 0; g < 16; g++) begin rd_grp = 4'(g); step(); end

    // R1: load the whole calendar; readback holds during writes (R2)
    tag = "R1";
    for (int a = 0; a < DEPTH; a++) begin
      cal_we_n = 1'b0; cal_addr = AW'(a); cal_wdata = CW'($urandom);
      rd_grp = 4'($urandom);
      step();
    end
    // R1/R2: readback of random entries
    tag = "R1/R2";
    cal_we_n = 1'b1;
    for (int i = 0; i < 200; i++) begin
      cal_addr = AW'($urandom); rd_grp = 4'($urandom); step();
    end

    // R3: plain walk, every slot valid, no framing values
    tag = "R3/R8";
    cfg_last = 9'd7; cfg_reps = 8'd0;
    for (int i = 0; i < 400; i++) begin
      stat_vld = 1'b1; stat_val = 2'($urandom_range(0, 2));
      rd_grp = 4'($urandom); cal_addr = AW'($urandom); step();
    end

    // R4: wrap and framing slot with repetitions, including length 0
    tag = "R4";
    for (int p = 0; p < 3; p++) begin
      cfg_last = AW'(p * 2); cfg_reps = RW'(2 - p);
      for (int i = 0; i < 300; i++) begin
        stat_vld = ($urandom_range(0, 1) == 1);
        stat_val = 2'($urandom_range(0, 2));
        rd_grp = 4'($urandom); step();
      end
    end

    // R5: mostly framing values
    tag = "R5";
    cfg_last = 9'd5; cfg_reps = 8'd1;
    for (int i = 0; i < 300; i++) begin
      stat_vld = 1'b1;
      stat_val = ($urandom_range(0, 3) != 0) ? 2'b11 : 2'($urandom_range(0, 2));
      rd_grp = 4'($urandom); step();
    end

    // R6: directed resync together with a valid slot
    tag = "R6";
    for (int i = 0; i < 4; i++) begin
      stat_vld = 1'b1; stat_val = 2'b00; resync = 1'b1; step();
      resync = 1'b0; stat_val = 2'b01; step();
    end
    for (int i = 0; i < 300; i++) begin
      resync = ($urandom_range(0, 9) == 0);
      stat_vld = ($urandom_range(0, 3) != 0);
      stat_val = 2'($urandom);
      rd_grp = 4'($urandom); step();
    end
    resync = 1'b0;

    // R10: nothing valid, inputs toggling
    tag = "R10";
    stat_vld = 1'b0;
    for (int i = 0; i < 200; i++) begin
      stat_val = 2'($urandom); rd_grp = 4'($urandom); step();
    end
    // after idle, the walk resumes where it stopped
    tag = "R10/R3";
    for (int i = 0; i < 40; i++) begin
      stat_vld = 1'b1; stat_val = 2'($urandom_range(0, 2));
      rd_grp = 4'($urandom); step();
    end

    // mixed random run
    tag = "R3/R4/R5/R6/R8";
    for (int i = 0; i < 12000; i++) begin
      if ($urandom_range(0, 199) == 0) begin
        cfg_last = AW'($urandom_range(0, 15));
        cfg_reps = RW'($urandom_range(0, 3));
      end
      cal_we_n = ($urandom_range(0, 19) != 0);
      cal_addr = AW'($urandom_range(0, 15));
      cal_wdata = CW'($urandom);
      resync = ($urandom_range(0, 59) == 0);
      stat_vld = ($urandom_range(0, 4) != 0);
      stat_val = 2'($urandom);
      rd_grp = 4'($urandom);
      step();
    end

    idle_inputs();
    // R8: final sweep of every group
    tag = "R8";
    for (int g = 0; g < 16; g++) begin rd_grp = 4'(g); step(); end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule